// File: doc/BRIEF.md
# Software Recall Sequence Controller

This block sits behind a simple synchronous memory port (chip enable, write enable, address, write data, read data) in front of a small working SRAM that has a nonvolatile shadow copy. Ordinary accesses read and write the working array, and reads return data one cycle later. The block also watches every chip-enabled read for a fixed six-address unlock pattern. When the last address of that pattern is read, it starts a recall: the working array is first wiped to zero, and the shadow contents are then copied into it word by word.

While the recall runs, a `busy` output stays high for a fixed, parameterised number of clock cycles. In that window writes from the port are dropped, reads return zero and the unlock detector does not advance. The shadow array is never written by this block, so a recall can be repeated as often as needed and always produces the same image. Filling the shadow store is outside this block. Its contents are a fixed function of the word index, set by parameters.

Top module: `recall_seq_ctrl`

## Requirements
- R1: When `busy` is low, a write (`ce`=1, `we`=1) stores `wdata` at word `addr[IDX_W-1:0]`, and a read (`ce`=1, `we`=0) presents that word on `rdata` after the next rising edge. `rdata` holds its value when no read is made.
- R2: Six chip-enabled reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0C63, in that order, start a recall. Idle cycles (`ce`=0) between them are allowed. `busy` is high after the edge that samples the sixth read.
- R3: Each read of the unlock pattern, including the sixth, returns the current array word, exactly like any other read.
- R4: The detector returns to the start on a chip-enabled write or on a read at an unexpected address, and then no recall follows. A read at 0x0E38 that breaks the pattern counts as its first step, so 0x31C7 is the next expected address.
- R5: `busy` stays high for exactly RECALL_CYC consecutive cycles per recall, and then falls.
- R6: While `busy` is high, writes have no effect, reads return 0 on `rdata`, and unlock reads are not counted.
- R7: After a recall, every word i of the working array holds (i*NV_MUL + NV_ADD) mod 2^DATA_W (default NV_MUL=37, NV_ADD=90, DATA_W=8). The array is cleared to zero before the copy starts.
- R8: Repeated recalls, with writes between them, always restore the same shadow image.
- R9: Reset drives `busy` and `rdata` to 0 and clears a partly matched unlock pattern. It leaves the working array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Chip enable; qualifies an access this cycle |
| we | input | 1 | Write enable; 1 = write, 0 = read |
| addr | input | ADDR_W | Access address; low IDX_W bits select the word |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| busy | output | 1 | High while a recall runs |

## Verification
The bench interleaves the unlock pattern with idle cycles, with a stray write, with a wrong address and with a repeated first address. A detector that failed to reset would start spurious recalls. One that treated a stray 0x0E38 as a plain mismatch would miss a valid pattern. The bench times the exact length of `busy` and fires writes, reads and a whole second unlock pattern into the busy window. A leaky guard would corrupt the restored image, return nonzero data or chain a second recall. Resetting halfway through a pattern and reading back the array afterwards catches a detector that keeps its state over reset and an array that is wiped by reset.

// File: rtl/recall_pkg.sv
// Package: shared types and the unlock address pattern for the recall controller.
// Assumes the pattern is fixed at six 14-bit addresses; wider buses zero-extend them.
package recall_pkg;

    localparam int SEQ_LEN   = 6;
    localparam int SEQ_ADR_W = 14;

    // Recall engine phases.
    typedef enum logic [1:0] {
        RC_IDLE,
        RC_CLEAR,
        RC_COPY,
        RC_HOLD
    } rc_state_t;

    // Expected address for a given step of the unlock pattern.
    function automatic logic [SEQ_ADR_W-1:0] seq_addr(input logic [2:0] step);
        logic [SEQ_ADR_W-1:0] a;
        case (step)
            3'd0:    a = 14'h0E38;
            3'd1:    a = 14'h31C7;
            3'd2:    a = 14'h03E0;
            3'd3:    a = 14'h3C1F;
            3'd4:    a = 14'h303F;
            3'd5:    a = 14'h0C63;
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/recall_seq_detect.sv
// Unlock detector: tracks how far the chip-enabled accesses have progressed
// through the six-read pattern and pulses fire on the final matching read.
// Assumes acc_valid is already masked while a recall is in progress.
module recall_seq_detect
    import recall_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              fire,
    output logic [2:0]        step
);

    localparam logic [2:0] LAST_STEP = 3'(SEQ_LEN - 1);

    logic [2:0] step_q;
    logic [2:0] step_d;
    logic       hit;
    logic       hit_first;

    // Compare the access address against the expected and the first pattern address.
    always_comb begin
        hit       = (acc_addr == ADDR_W'(seq_addr(step_q)));
        hit_first = (acc_addr == ADDR_W'(seq_addr(3'd0)));
    end

    // Next-step decision for one chip-enabled access.
    always_comb begin
        step_d = step_q;
        fire   = 1'b0;
        if (acc_valid) begin
            if (acc_write) begin
                step_d = 3'd0;
            end else if (hit) begin
                if (step_q == LAST_STEP) begin
                    step_d = 3'd0;
                    fire   = 1'b1;
                end else begin
                    step_d = step_q + 3'd1;
                end
            end else if (hit_first) begin
                step_d = 3'd1;
            end else begin
                step_d = 3'd0;
            end
        end
    end

    // Step register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= 3'd0;
        else        step_q <= step_d;
    end

    assign step = step_q;

endmodule

// File: rtl/recall_shadow.sv
// Shadow nonvolatile image: a fixed, read-only word per index computed from
// NV_MUL and NV_ADD. Nothing in this block writes it.
module recall_shadow #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int NV_MUL = 37,
    parameter int NV_ADD = 90,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] image [DEPTH];

    // One constant word per index.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign image[g] = DATA_W'(g * NV_MUL + NV_ADD);
    end

    // Combinational lookup.
    assign rd_data = image[rd_idx];

endmodule

// File: rtl/recall_sram.sv
// Working SRAM: one write port and one registered read port.
// The array itself has no reset. Only the read register is reset.
// rd_zero forces the returned word to zero (used while a recall runs).
module recall_sram #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_zero,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Array write, deliberately kept out of reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Registered read data, holding between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_zero ? '0 : mem[rd_idx];
    end

endmodule

// File: rtl/recall_engine.sv
// Recall engine: on start it walks every index once to write zero, then walks
// again to copy the shadow word, then waits until RECALL_CYC cycles have passed.
// Assumes RECALL_CYC >= 2*DEPTH, and ignores start while busy.
module recall_engine
    import recall_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int DATA_W     = 8,
    parameter int RECALL_CYC = 40,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(RECALL_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] sh_data,
    output logic [IDX_W-1:0]  ptr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output rc_state_t         state
);

    localparam logic [IDX_W-1:0] PTR_LAST = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECALL_CYC - 1);

    rc_state_t        st_q;
    logic [IDX_W-1:0] ptr_q;
    logic [CNT_W-1:0] cnt_q;

    // Phase sequencing, word pointer and cycle-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RC_IDLE;
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            case (st_q)
                RC_IDLE: begin
                    if (start) begin
                        st_q  <= RC_CLEAR;
                        ptr_q <= '0;
                        cnt_q <= '0;
                    end
                end
                RC_CLEAR: begin
                    cnt_q <= cnt_q + 1'b1;
                    ptr_q <= ptr_q + 1'b1;
                    if (ptr_q == PTR_LAST) begin
                        st_q  <= RC_COPY;
                        ptr_q <= '0;
                    end
                end
                RC_COPY: begin
                    cnt_q <= cnt_q + 1'b1;
                    ptr_q <= ptr_q + 1'b1;
                    if (ptr_q == PTR_LAST) begin
                        st_q <= (cnt_q == CNT_LAST) ? RC_IDLE : RC_HOLD;
                    end
                end
                RC_HOLD: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_LAST) st_q <= RC_IDLE;
                end
                default: st_q <= RC_IDLE;
            endcase
        end
    end

    // Array write request for the current phase.
    always_comb begin
        wr_en   = (st_q == RC_CLEAR) || (st_q == RC_COPY);
        wr_data = (st_q == RC_COPY) ? sh_data : '0;
    end

    assign ptr   = ptr_q;
    assign busy  = (st_q != RC_IDLE);
    assign state = st_q;

endmodule

// File: rtl/recall_seq_ctrl.sv
// Top: memory port in front of the working SRAM, the unlock detector and the
// recall engine. While busy, port writes are dropped, reads return zero and the
// detector sees no accesses. Reset leaves both arrays unchanged.
module recall_seq_ctrl
    import recall_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 16,
    parameter int RECALL_CYC = 40,
    parameter int NV_MUL     = 37,
    parameter int NV_ADD     = 90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);

    localparam int IDX_W = $clog2(DEPTH);

    logic              seq_fire;
    logic [2:0]        seq_step;
    logic              eng_busy;
    logic              eng_we;
    logic [DATA_W-1:0] eng_wdata;
    logic [IDX_W-1:0]  eng_ptr;
    logic [DATA_W-1:0] sh_data;
    rc_state_t         eng_state;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_widx;
    logic [DATA_W-1:0] mem_wdata;
    logic              port_ok;

    // Port accesses count only while no recall runs.
    assign port_ok = ce && !eng_busy;

    recall_seq_detect #(.ADDR_W(ADDR_W)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (port_ok),
        .acc_write (we),
        .acc_addr  (addr),
        .fire      (seq_fire),
        .step      (seq_step)
    );

    recall_shadow #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .NV_MUL (NV_MUL),
        .NV_ADD (NV_ADD)
    ) u_shadow (
        .rd_idx  (eng_ptr),
        .rd_data (sh_data)
    );

    recall_engine #(
        .DEPTH      (DEPTH),
        .DATA_W     (DATA_W),
        .RECALL_CYC (RECALL_CYC)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (seq_fire),
        .sh_data (sh_data),
        .ptr     (eng_ptr),
        .wr_en   (eng_we),
        .wr_data (eng_wdata),
        .busy    (eng_busy),
        .state   (eng_state)
    );

    // Write port select: the engine owns the array while busy, the port otherwise.
    always_comb begin
        if (eng_busy) begin
            mem_we    = eng_we;
            mem_widx  = eng_ptr;
            mem_wdata = eng_wdata;
        end else begin
            mem_we    = ce && we;
            mem_widx  = addr[IDX_W-1:0];
            mem_wdata = wdata;
        end
    end

    recall_sram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_sram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_idx  (mem_widx),
        .wr_data (mem_wdata),
        .rd_en   (ce && !we),
        .rd_zero (eng_busy),
        .rd_idx  (addr[IDX_W-1:0]),
        .rd_data (rdata)
    );

    assign busy = eng_busy;

endmodule

// File: rtl/recall_seq_ctrl_chk.sv
// Checker: temporal properties of the recall controller, bound to the top module.
// Keeps its own count of the busy window instead of a long $past.
module recall_seq_ctrl_chk #(
    parameter int DATA_W     = 8,
    parameter int RECALL_CYC = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic              we,
    input logic              busy,
    input logic [DATA_W-1:0] rdata,
    input logic              fire,
    input logic [2:0]        step
);

    localparam int CNT_W = $clog2(RECALL_CYC + 2);

    logic [CNT_W-1:0] run_len;

    // Length of the current busy run, in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R2: the final unlock read starts the recall on the next cycle.
    p_busy_after_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> busy);

    // R2: busy only rises as a result of a detector fire.
    p_rise_needs_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && $past(rst_n) |-> $past(fire));

    // R4: a chip-enabled write outside a recall returns the detector to the start.
    p_write_resets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ce && we && !busy |=> step == 3'd0);

    // R5: the busy window lasts exactly RECALL_CYC cycles.
    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && $past(rst_n) |-> run_len == CNT_W'(RECALL_CYC));

    // R6: reads during a recall return zero, and no new recall can fire.
    p_rd_zero_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ce && !we |=> rdata == '0);

    p_no_fire_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !fire);

endmodule

bind recall_seq_ctrl recall_seq_ctrl_chk #(
    .DATA_W     (DATA_W),
    .RECALL_CYC (RECALL_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .we    (we),
    .busy  (busy),
    .rdata (rdata),
    .fire  (seq_fire),
    .step  (seq_step)
);

// File: tb/recall_seq_ctrl_bench.sv
// Bench: directed unlock-pattern cases mixed with seeded random traffic,
// checked against a bench-side array model and the shadow formula.
module recall_seq_ctrl_bench;

    localparam int ADDR_W = 14;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int RC     = 40;
    localparam int NVM    = 37;
    localparam int NVA    = 90;
    localparam int IDX_W  = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              busy;

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] model [DEPTH];

    localparam logic [ADDR_W-1:0] SEQ [6] = '{14'h0E38, 14'h31C7, 14'h03E0,
                                              14'h3C1F, 14'h303F, 14'h0C63};

    recall_seq_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
        .RECALL_CYC(RC), .NV_MUL(NVM), .NV_ADD(NVA)
    ) u_recall_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    always #2 clk = ~clk;

    function automatic logic [DATA_W-1:0] nv_word(input int i);
        return DATA_W'(i * NVM + NVA);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        ce = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        ce = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        ce = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        ce = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Count the remaining busy cycles, sampled at falling edges.
    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 4 * RC) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_image(input string req);
        logic [DATA_W-1:0] d;
        for (int i = 0; i < DEPTH; i++) begin
            rd(ADDR_W'(i), d);
            chk(req, d, nv_word(i));
            model[i] = nv_word(i);
        end
    endtask

    // Full unlock pattern with data checks, busy start and length checks.
    task automatic full_recall(input bit gaps);
        logic [DATA_W-1:0] d;
        int n;
        for (int s = 0; s < 6; s++) begin
            rd(SEQ[s], d);
            chk("R3 pattern read data", d, model[SEQ[s][IDX_W-1:0]]);
            if (gaps) idle(2);
        end
        if (gaps) chk("R2 busy after pattern with idle gaps", busy, 1'b1);
        else      chk("R2 busy after pattern", busy, 1'b1);
        busy_len(n);
        chk("R5 busy length", n, RC - (gaps ? 2 : 0));
        check_image("R7 image after recall");
    endtask

    initial begin : watchdog
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [DATA_W-1:0] d;
        int n;
        void'($urandom(32'h5EED_1234));

        idle(3);
        chk("R9 busy in reset", busy, 1'b0);
        chk("R9 rdata in reset", rdata, '0);
        @(negedge clk) rst_n = 1'b1;

        // R1: fill and read back.
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = DATA_W'($urandom);
            wr(ADDR_W'(i), model[i]);
        end
        for (int i = 0; i < DEPTH; i++) begin
            rd(ADDR_W'(i), d);
            chk("R1 readback", d, model[i]);
        end
        idle(1);
        chk("R1 rdata holds without read", rdata, model[DEPTH-1]);

        // R2/R3/R5/R7: a plain recall.
        full_recall(1'b0);

        // R4: wrong address in the middle, then the rest: no recall.
        for (int s = 0; s < 3; s++) rd(SEQ[s], d);
        rd(14'h1234, d);
        for (int s = 3; s < 6; s++) rd(SEQ[s], d);
        idle(1);
        chk("R4 no recall after wrong address", busy, 1'b0);

        // R4: a write in the middle breaks the pattern.
        for (int s = 0; s < 4; s++) rd(SEQ[s], d);
        wr(14'h0002, 8'h5A); model[2] = 8'h5A;
        for (int s = 4; s < 6; s++) rd(SEQ[s], d);
        idle(1);
        chk("R4 no recall after write", busy, 1'b0);
        rd(14'h0002, d);
        chk("R1 write between pattern reads", d, 8'h5A);

        // R4: a stray first address restarts at step two.
        rd(SEQ[0], d); rd(SEQ[1], d); rd(SEQ[0], d);
        for (int s = 1; s < 6; s++) rd(SEQ[s], d);
        chk("R4 restart on first address", busy, 1'b1);
        busy_len(n);
        chk("R5 busy length after restart", n, RC);
        check_image("R7 image after restart recall");

        // R2: idle cycles between pattern reads are allowed.
        wr(14'h0007, 8'h11); model[7] = 8'h11;
        full_recall(1'b1);

        // R6: writes, reads and a second pattern during busy.
        for (int s = 0; s < 6; s++) rd(SEQ[s], d);
        chk("R2 busy for R6 test", busy, 1'b1);
        wr(14'h0005, 8'hEE);
        rd(14'h0005, d);
        chk("R6 read during busy is zero", d, '0);
        for (int s = 0; s < 6; s++) rd(SEQ[s], d);
        busy_len(n);
        chk("R6 busy not extended by second pattern", n, RC - 16);
        idle(3);
        chk("R6 no recall from pattern during busy", busy, 1'b0);
        check_image("R6 write during busy ignored");

        // R8: random writes then recall again, twice.
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < 20; k++) begin
                int i = int'($urandom % DEPTH);
                model[i] = DATA_W'($urandom);
                wr(ADDR_W'(i), model[i]);
            end
            for (int s = 0; s < 6; s++) rd(SEQ[s], d);
            busy_len(n);
            check_image("R8 repeated recall image");
        end

        // R9: reset halfway through a pattern clears the detector, keeps the array.
        wr(14'h0009, 8'hC3); model[9] = 8'hC3;
        rd(SEQ[0], d); rd(SEQ[1], d);
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        chk("R9 rdata after reset", rdata, '0);
        @(negedge clk) rst_n = 1'b1;
        for (int s = 2; s < 6; s++) rd(SEQ[s], d);
        idle(1);
        chk("R9 detector cleared by reset", busy, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            rd(ADDR_W'(i), d);
            chk("R9 array kept over reset", d, model[i]);
        end

        // R1: seeded random traffic against the model.
        for (int k = 0; k < 300; k++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'($urandom);
            if ($urandom % 2 == 0) begin
                model[a[IDX_W-1:0]] = DATA_W'($urandom);
                wr(a, model[a[IDX_W-1:0]]);
            end else begin
                rd(a, d);
                chk("R1 random read", d, model[a[IDX_W-1:0]]);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule